// File: doc/BRIEF.md
# Pointer Address Generation Unit

This block forms data-memory addresses for indirect loads and stores, for stack pushes and pops, and for program-memory reads that go through the Z pointer. It holds three 16-bit pointers (X, Y, Z) and a 10-bit stack pointer. For each accepted request it computes the effective address, writes back the updated pointer if the mode calls for it, and runs the access for its fixed number of clocks. On the last clock it raises `done` together with exactly one memory strobe.

Requests arrive on a valid/ready interface. `req_ready` is high only while the unit is idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. While `req_valid` is high and `req_ready` is low, the requester must hold the request fields steady. `req_ready` stays low from the accepting edge through the `done` cycle, so back-to-back requests are spaced by the access length. A separate plain load port lets the surrounding datapath set any pointer while the unit is idle.

Top module: `ptr_agu`

## Requirements
- R1: After reset, all four pointers read 0, `req_ready` is 1, and `done`, `mem_rd`, `mem_wr` and `pm_rd` are 0.
- R2: When idle and no request is accepted on the same edge, `ld_en` writes `ld_data` into the register chosen by `ld_sel` (0 X, 1 Y, 2 Z, 3 stack pointer from bits 9:0). The new value shows on the pointer port in the following cycle. If a request is accepted on that edge, the request wins.
- R3: Pointer select `req_sel` is 0 for X, 1 for Y, and 2 or 3 for Z. Op 0 (plain) addresses at the pointer and leaves it unchanged. Op 1 (post-increment) addresses at the pointer and stores pointer+1.
- R4: Op 2 (pre-decrement) forms pointer-1, uses it as the address and stores it.
- R5: Op 3 (displacement) addresses Y or Z plus the unsigned 6-bit `req_disp` (0..63) without changing the pointer. With X selected it acts as plain indirect.
- R6: Op 4 reads program memory at Z. Op 5 does the same and then stores Z+1. Both ignore `req_sel`.
- R7: Op 6 (push) writes at the stack pointer and then stores SP-1. Op 7 (pop) forms SP+1, reads there and stores it. Stack addresses are zero-extended to 16 bits.
- R8: X, Y and Z arithmetic wraps modulo 2^16. Stack pointer arithmetic wraps modulo 2^10.
- R9: `done` is high on the 2nd cycle after the accepting edge for ops 0-3, 6 and 7, and on the 3rd cycle for ops 4 and 5. `req_ready` is low from the accepting edge until the edge after `done`.
- R10: A strobe is high only together with `done`, and exactly one is high then. `mem_wr` is used for data stores (`req_store`=1 on ops 0-3) and for pushes. `mem_rd` is used for data loads and pops. `pm_rd` is used for ops 4 and 5.
- R11: Pointer updates are visible from the first cycle after acceptance. `mem_addr` stays constant throughout the access.
- R12: `ld_en` has no effect while an access is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle, request may be taken |
| req_op | input | 3 | Addressing mode (0..7, see R3-R7) |
| req_sel | input | 2 | Pointer select: 0 X, 1 Y, 2/3 Z |
| req_disp | input | 6 | Unsigned displacement |
| req_store | input | 1 | 1 = data store, 0 = data load (ops 0-3) |
| ld_en | input | 1 | Direct pointer load enable |
| ld_sel | input | 2 | Pointer to load: 0 X, 1 Y, 2 Z, 3 SP |
| ld_data | input | 16 | Load value |
| mem_addr | output | 16 | Effective address of current access |
| mem_rd | output | 1 | Data read strobe |
| mem_wr | output | 1 | Data write strobe |
| pm_rd | output | 1 | Program-memory read strobe |
| done | output | 1 | Final cycle of the access |
| ptr_x | output | 16 | X pointer |
| ptr_y | output | 16 | Y pointer |
| ptr_z | output | 16 | Z pointer |
| ptr_sp | output | 10 | Stack pointer |

## Verification
A wrong write-back shows on the pointer ports one cycle after the accepting edge. A wrong address shows on `mem_addr` in that same cycle and persists until `done`. A sequencer counting the wrong length moves `done` and the strobe off the 2nd or 3rd cycle, which the scoreboard sees as a latency mismatch on that same access. A stale or wrongly wrapped pointer usually passes its own access but corrupts the address of the next one, so the tests chain requests across the wrap points.

// File: rtl/agu_pkg.sv
package agu_pkg;
  typedef enum logic [2:0] {
    OP_IND   = 3'd0,
    OP_PINC  = 3'd1,
    OP_PDEC  = 3'd2,
    OP_DISP  = 3'd3,
    OP_PM    = 3'd4,
    OP_PMINC = 3'd5,
    OP_PUSH  = 3'd6,
    OP_POP   = 3'd7
  } agu_op_e;

  typedef enum logic [1:0] {
    AK_NONE = 2'd0,
    AK_RD   = 2'd1,
    AK_WR   = 2'd2,
    AK_PM   = 2'd3
  } acc_kind_e;

  localparam int DATA_CYCLES = 2;
  localparam int PM_CYCLES   = 3;
endpackage

// File: rtl/agu_ptr_file.sv
module agu_ptr_file #(
  parameter int PW  = 16,
  parameter int SPW = 10
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wb_en,
  input  logic [1:0]     wb_sel,
  input  logic [PW-1:0]  wb_val,
  output logic [PW-1:0]  x_o,
  output logic [PW-1:0]  y_o,
  output logic [PW-1:0]  z_o,
  output logic [SPW-1:0] sp_o
);
  localparam int NPTR = 3;
  logic [PW-1:0] regs [NPTR];
  logic [SPW-1:0] sp_q;

  for (genvar g = 0; g < NPTR; g++) begin : g_ptr
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) regs[g] <= '0;
      else if (wb_en && wb_sel == 2'(g)) regs[g] <= wb_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sp_q <= '0;
    else if (wb_en && wb_sel == 2'd3) sp_q <= wb_val[SPW-1:0];
  end

  assign x_o  = regs[0];
  assign y_o  = regs[1];
  assign z_o  = regs[2];
  assign sp_o = sp_q;
endmodule

// File: rtl/agu_addr_calc.sv
module agu_addr_calc
  import agu_pkg::*;
#(
  parameter int PW  = 16,
  parameter int SPW = 10,
  parameter int DW  = 6
) (
  input  agu_op_e        op,
  input  logic [1:0]     sel,
  input  logic [DW-1:0]  disp,
  input  logic           store,
  input  logic [PW-1:0]  x,
  input  logic [PW-1:0]  y,
  input  logic [PW-1:0]  z,
  input  logic [SPW-1:0] sp,
  output logic [PW-1:0]  addr,
  output logic [PW-1:0]  nval,
  output logic           wb,
  output logic [1:0]     tsel,
  output acc_kind_e      kind
);
  localparam logic [PW-1:0]  P_ONE  = PW'(1);
  localparam logic [SPW-1:0] S_ONE  = SPW'(1);
  localparam int             SP_PAD = PW - SPW;
  localparam int             DS_PAD = PW - DW;

  logic [PW-1:0]  base;
  logic [SPW-1:0] sp_dn, sp_up;

  assign sp_dn = sp - S_ONE;
  assign sp_up = sp + S_ONE;

  always_comb begin
    case (sel)
      2'd0:    base = x;
      2'd1:    base = y;
      default: base = z;
    endcase
    addr = base;
    nval = base;
    wb   = 1'b0;
    tsel = (sel == 2'd3) ? 2'd2 : sel;
    kind = store ? AK_WR : AK_RD;
    case (op)
      OP_PINC: begin
        nval = base + P_ONE;
        wb   = 1'b1;
      end
      OP_PDEC: begin
        nval = base - P_ONE;
        addr = base - P_ONE;
        wb   = 1'b1;
      end
      OP_DISP: begin
        if (sel != 2'd0) addr = base + {{DS_PAD{1'b0}}, disp};
      end
      OP_PM: begin
        addr = z;
        nval = z;
        tsel = 2'd2;
        kind = AK_PM;
      end
      OP_PMINC: begin
        addr = z;
        nval = z + P_ONE;
        wb   = 1'b1;
        tsel = 2'd2;
        kind = AK_PM;
      end
      OP_PUSH: begin
        addr = {{SP_PAD{1'b0}}, sp};
        nval = {{SP_PAD{1'b0}}, sp_dn};
        wb   = 1'b1;
        tsel = 2'd3;
        kind = AK_WR;
      end
      OP_POP: begin
        addr = {{SP_PAD{1'b0}}, sp_up};
        nval = {{SP_PAD{1'b0}}, sp_up};
        wb   = 1'b1;
        tsel = 2'd3;
        kind = AK_RD;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/agu_seq.sv
module agu_seq #(
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] len_m1,
  output logic          busy,
  output logic          done
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= len_m1;
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - CW'(1);
    end
  end

  assign done = busy && (cnt == '0);
endmodule

// File: rtl/ptr_agu.sv
module ptr_agu
  import agu_pkg::*;
#(
  parameter int PW  = 16,
  parameter int SPW = 10,
  parameter int DW  = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid,
  output logic           req_ready,
  input  logic [2:0]     req_op,
  input  logic [1:0]     req_sel,
  input  logic [DW-1:0]  req_disp,
  input  logic           req_store,
  input  logic           ld_en,
  input  logic [1:0]     ld_sel,
  input  logic [PW-1:0]  ld_data,
  output logic [PW-1:0]  mem_addr,
  output logic           mem_rd,
  output logic           mem_wr,
  output logic           pm_rd,
  output logic           done,
  output logic [PW-1:0]  ptr_x,
  output logic [PW-1:0]  ptr_y,
  output logic [PW-1:0]  ptr_z,
  output logic [SPW-1:0] ptr_sp
);
  localparam int CW = $clog2(PM_CYCLES + 1);

  logic          busy, accept;
  logic [PW-1:0] c_addr, c_nval;
  logic          c_wb;
  logic [1:0]    c_tsel;
  acc_kind_e     c_kind, kind_q;
  logic          wb_en;
  logic [1:0]    wb_sel;
  logic [PW-1:0] wb_val;
  logic [PW-1:0] addr_q;
  logic [CW-1:0] len_m1;

  assign req_ready = !busy;
  assign accept    = req_valid && !busy;

  agu_addr_calc #(.PW(PW), .SPW(SPW), .DW(DW)) u_calc (
    .op    (agu_op_e'(req_op)),
    .sel   (req_sel),
    .disp  (req_disp),
    .store (req_store),
    .x     (ptr_x),
    .y     (ptr_y),
    .z     (ptr_z),
    .sp    (ptr_sp),
    .addr  (c_addr),
    .nval  (c_nval),
    .wb    (c_wb),
    .tsel  (c_tsel),
    .kind  (c_kind)
  );

  always_comb begin
    if (accept) begin
      wb_en  = c_wb;
      wb_sel = c_tsel;
      wb_val = c_nval;
    end else begin
      wb_en  = ld_en && !busy;
      wb_sel = ld_sel;
      wb_val = ld_data;
    end
  end

  agu_ptr_file #(.PW(PW), .SPW(SPW)) u_ptrs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wb_en  (wb_en),
    .wb_sel (wb_sel),
    .wb_val (wb_val),
    .x_o    (ptr_x),
    .y_o    (ptr_y),
    .z_o    (ptr_z),
    .sp_o   (ptr_sp)
  );

  assign len_m1 = (c_kind == AK_PM) ? CW'(PM_CYCLES - 1) : CW'(DATA_CYCLES - 1);

  agu_seq #(.CW(CW)) u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (accept),
    .len_m1 (len_m1),
    .busy   (busy),
    .done   (done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      kind_q <= AK_NONE;
    end else if (accept) begin
      addr_q <= c_addr;
      kind_q <= c_kind;
    end
  end

  assign mem_addr = addr_q;
  assign mem_rd   = done && (kind_q == AK_RD);
  assign mem_wr   = done && (kind_q == AK_WR);
  assign pm_rd    = done && (kind_q == AK_PM);
endmodule

// File: rtl/agu_chk.sv
module agu_chk #(
  parameter int PW  = 16,
  parameter int SPW = 10
) (
  input logic           clk,
  input logic           rst_n,
  input logic           req_valid,
  input logic           req_ready,
  input logic [2:0]     req_op,
  input logic           done,
  input logic           mem_rd,
  input logic           mem_wr,
  input logic           pm_rd,
  input logic [PW-1:0]  mem_addr,
  input logic [PW-1:0]  ptr_x,
  input logic [PW-1:0]  ptr_y,
  input logic [PW-1:0]  ptr_z,
  input logic [SPW-1:0] ptr_sp
);
  logic acc, pm_op;
  assign acc   = req_valid && req_ready;
  assign pm_op = (req_op == 3'd4) || (req_op == 3'd5);

  // R9
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> !req_ready);

  // R9
  data_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !pm_op) |=> !done ##1 done);

  // R9
  pm_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && pm_op) |=> !done ##1 !done ##1 done);

  // R9
  ready_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> req_ready);

  // R10
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_rd, mem_wr, pm_rd}));

  // R10
  strobe_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || mem_wr || pm_rd) |-> done);

  // R10
  done_has_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (mem_rd || mem_wr || pm_rd));

  // R11
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && !done) |=> $stable(mem_addr));

  // R12
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |=> $stable({ptr_x, ptr_y, ptr_z, ptr_sp}));
endmodule

bind ptr_agu agu_chk #(.PW(PW), .SPW(SPW)) u_agu_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_op    (req_op),
  .done      (done),
  .mem_rd    (mem_rd),
  .mem_wr    (mem_wr),
  .pm_rd     (pm_rd),
  .mem_addr  (mem_addr),
  .ptr_x     (ptr_x),
  .ptr_y     (ptr_y),
  .ptr_z     (ptr_z),
  .ptr_sp    (ptr_sp)
);

// File: tb/tb_ptr_agu.sv
module tb_ptr_agu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [2:0]  req_op = '0;
  logic [1:0]  req_sel = '0;
  logic [5:0]  req_disp = '0;
  logic        req_store = 1'b0;
  logic        ld_en = 1'b0;
  logic [1:0]  ld_sel = '0;
  logic [15:0] ld_data = '0;
  logic [15:0] mem_addr;
  logic        mem_rd, mem_wr, pm_rd, done;
  logic [15:0] ptr_x, ptr_y, ptr_z;
  logic [9:0]  ptr_sp;

  always #4 clk = ~clk;

  ptr_agu dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_sel(req_sel), .req_disp(req_disp), .req_store(req_store),
    .ld_en(ld_en), .ld_sel(ld_sel), .ld_data(ld_data), .mem_addr(mem_addr),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .pm_rd(pm_rd), .done(done),
    .ptr_x(ptr_x), .ptr_y(ptr_y), .ptr_z(ptr_z), .ptr_sp(ptr_sp)
  );

  typedef struct {
    logic [15:0] addr;
    logic [2:0]  strb;
    int          lat;
    logic [15:0] ex, ey, ez;
    logic [9:0]  esp;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  int          checks = 0;
  int          fails = 0;
  int          cyc = 0;
  int          acc_cyc = 0;
  logic [15:0] mx = '0, my = '0, mz = '0;
  logic [9:0]  msp = '0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // strobe code {pm_rd, mem_wr, mem_rd}
  task automatic issue(input logic [2:0] op, input logic [1:0] sel, input logic [5:0] q,
                       input logic st, input string tag);
    exp_t e;
    logic [15:0] b;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    b = (sel == 2'd0) ? mx : (sel == 2'd1) ? my : mz;
    e.lat = 2;
    e.strb = st ? 3'b010 : 3'b001;
    e.addr = b;
    case (op)
      3'd1: begin
        if (sel == 2'd0) mx = b + 16'd1; else if (sel == 2'd1) my = b + 16'd1; else mz = b + 16'd1;
      end
      3'd2: begin
        e.addr = b - 16'd1;
        if (sel == 2'd0) mx = b - 16'd1; else if (sel == 2'd1) my = b - 16'd1; else mz = b - 16'd1;
      end
      3'd3: if (sel != 2'd0) e.addr = b + {10'd0, q};
      3'd4: begin e.addr = mz; e.strb = 3'b100; e.lat = 3; end
      3'd5: begin e.addr = mz; e.strb = 3'b100; e.lat = 3; mz = mz + 16'd1; end
      3'd6: begin e.addr = {6'd0, msp}; e.strb = 3'b010; msp = msp - 10'd1; end
      3'd7: begin msp = msp + 10'd1; e.addr = {6'd0, msp}; e.strb = 3'b001; end
      default: ;
    endcase
    e.ex = mx; e.ey = my; e.ez = mz; e.esp = msp; e.tag = tag;
    sb.push_back(e);
    req_valid = 1'b1; req_op = op; req_sel = sel; req_disp = q; req_store = st;
    acc_cyc = cyc;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (!req_ready || sb.size() != 0) @(negedge clk);
  endtask

  task automatic load(input logic [1:0] sel, input logic [15:0] v);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    ld_en = 1'b1; ld_sel = sel; ld_data = v;
    @(negedge clk);
    ld_en = 1'b0;
    case (sel)
      2'd0: mx = v;
      2'd1: my = v;
      2'd2: mz = v;
      default: msp = v[9:0];
    endcase
    check(ptr_x == mx && ptr_y == my && ptr_z == mz && ptr_sp == msp,
          "R2 pointer load", {ptr_x, ptr_y, ptr_z}, {mx, my, mz});
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (sb.size() == 0) begin
        check(1'b0, "R9 done with no pending access", 1, 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(mem_addr == e.addr, {e.tag, " address"}, mem_addr, e.addr);
        check({pm_rd, mem_wr, mem_rd} == e.strb, {"R10 strobe ", e.tag}, {pm_rd, mem_wr, mem_rd}, e.strb);
        check(cyc - acc_cyc == e.lat, {"R9 latency ", e.tag}, cyc - acc_cyc, e.lat);
        check(ptr_x == e.ex && ptr_y == e.ey && ptr_z == e.ez,
              {"R11 pointers ", e.tag}, {ptr_x, ptr_y, ptr_z}, {e.ex, e.ey, e.ez});
        check(ptr_sp == e.esp, {"R11 sp ", e.tag}, ptr_sp, e.esp);
      end
    end
  end

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R9 watchdog expired act=0 exp=1");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(req_ready == 1'b1 && done == 1'b0, "R1 ready/done in reset", {req_ready, done}, 2'b10);
    check({mem_rd, mem_wr, pm_rd} == 3'b000, "R1 strobes in reset", {mem_rd, mem_wr, pm_rd}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(ptr_x == 0 && ptr_y == 0 && ptr_z == 0 && ptr_sp == 0, "R1 pointers zero",
          {ptr_x, ptr_y, ptr_z, ptr_sp}, 0);

    // R2 loads
    load(2'd0, 16'h1000);
    load(2'd1, 16'h2000);
    load(2'd2, 16'hFFFF);
    load(2'd3, 16'hF002);

    // R3 plain and post-increment
    issue(3'd0, 2'd0, 6'd0, 1'b0, "R3 plain X load"); wait_idle();
    issue(3'd1, 2'd0, 6'd0, 1'b1, "R3 postinc X store"); wait_idle();
    issue(3'd1, 2'd0, 6'd0, 1'b0, "R3 postinc X again"); wait_idle();
    // R4 pre-decrement
    issue(3'd2, 2'd1, 6'd0, 1'b0, "R4 predec Y"); wait_idle();
    // R8 Z wraps FFFF -> 0 on post-increment (sel 3 is Z)
    issue(3'd1, 2'd3, 6'd0, 1'b1, "R8 postinc Z wrap"); wait_idle();
    // R8 Z pre-decrement from 0 wraps to FFFF
    issue(3'd2, 2'd2, 6'd0, 1'b0, "R8 predec Z wrap"); wait_idle();
    // R5 displacement
    issue(3'd3, 2'd1, 6'd63, 1'b0, "R5 disp Y 63"); wait_idle();
    issue(3'd3, 2'd2, 6'd0, 1'b1, "R5 disp Z 0"); wait_idle();
    issue(3'd3, 2'd0, 6'd5, 1'b0, "R5 disp on X acts plain"); wait_idle();
    issue(3'd3, 2'd2, 6'd17, 1'b0, "R8 disp Z wraps"); wait_idle();
    // R6 program memory reads
    load(2'd2, 16'h0400);
    issue(3'd4, 2'd0, 6'd0, 1'b0, "R6 pm read sel ignored"); wait_idle();
    issue(3'd5, 2'd1, 6'd0, 1'b0, "R6 pm read inc"); wait_idle();
    issue(3'd5, 2'd2, 6'd0, 1'b0, "R6 pm read inc again"); wait_idle();
    // R7 push/pop including SP wrap
    issue(3'd6, 2'd0, 6'd0, 1'b0, "R7 push at 2"); wait_idle();
    load(2'd3, 16'h0000);
    issue(3'd6, 2'd0, 6'd0, 1'b0, "R8 push at 0 wraps SP"); wait_idle();
    issue(3'd7, 2'd0, 6'd0, 1'b1, "R8 pop at 3FF wraps"); wait_idle();
    issue(3'd7, 2'd0, 6'd0, 1'b0, "R7 pop"); wait_idle();

    // R12 load attempt while busy
    issue(3'd1, 2'd1, 6'd0, 1'b0, "R12 access under load attempt");
    ld_en = 1'b1; ld_sel = 2'd0; ld_data = 16'hDEAD;
    @(negedge clk);
    ld_en = 1'b0;
    wait_idle();
    check(ptr_x == mx, "R12 X unchanged after busy load", ptr_x, mx);

    // back-to-back requests (R9)
    issue(3'd1, 2'd0, 6'd0, 1'b0, "R9 b2b 1");
    issue(3'd4, 2'd0, 6'd0, 1'b0, "R9 b2b 2");
    issue(3'd6, 2'd0, 6'd0, 1'b0, "R9 b2b 3");
    wait_idle();

    repeat (3) @(negedge clk);
    summary();
    $finish;
  end
endmodule